// File: doc/BRIEF.md
# Caller-ID Front-End Mode Controller

This block turns a three-bit static control code into the run enables of a caller-identity receiver: the frequency-shift-keyed (FSK) demodulator with its serial read mode, alert-tone detection on the hybrid receive path, and alert-tone detection on the tip/ring path. The code bits come from a slow external source, so each is resynchronised before use. Only one function is enabled at a time. An unused path is switched off by mode alone.

The block also owns the pins that different functions share or that must rest at fixed levels. It chooses whether the shared active-low strobe pin carries the byte-ready flag or the qualified alert flag. It gates the data, carrier and alert pins by the active function, and drives idle levels whenever no function runs. The power-down code takes effect only after it has been held for `PD_HOLD` clocks in a row. A shorter visit leaves the previous function running and ends with a one-clock core reset pulse when the code moves away.

Top module: `call_mode_ctrl`

## Requirements
- R1: With code bits `cfg_i[2:0]` = {read mode, select high, select low}, code 3'b011 gives `fsk_en_o`=1, `rd_mode_o`=0 and code 3'b111 gives `fsk_en_o`=1, `rd_mode_o`=1, three clocks after the code is applied.
- R2: Code x10 gives `hyb_alert_en_o`=1 and code x01 gives `tr_alert_en_o`=1, whatever bit 2 holds; `rd_mode_o` is 0 in both.
- R3: At no time is more than one of `fsk_en_o`, `hyb_alert_en_o`, `tr_alert_en_o` high.
- R4: Once code 3'b100 has been held long enough, `pwrdn_o` rises `PD_HOLD`+2 clocks after the code is applied (not one clock sooner), and all function enables are low while it is high.
- R5: If code 3'b100 is left before power-down takes effect, `pwrdn_o` stays low, the enables keep their previous values during the visit, and `core_rst_o` is high for exactly the third clock after the new code is applied.
- R6: Leaving a power-down that has taken effect produces no `core_rst_o` pulse, and `pwrdn_o` falls three clocks after the new code is applied.
- R7: While `pwrdn_o` is high or the test code 3'b000 is in force, `data_o`, `strobe_n_o` and `carrier_n_o` are 1 and `early_o` and `guard_o` are 0, whatever the core inputs hold.
- R8: Test code 3'b000 clears all function enables and leaves `pwrdn_o` low; it is also the state right after reset.
- R9: `strobe_n_o` follows `ready_n_i` in FSK read mode 1, is 1 in FSK mode 0, and follows `steer_n_i` while either alert path is enabled.
- R10: With FSK enabled, `early_o` and `guard_o` are 0. With an alert path enabled, `data_o` and `carrier_n_o` are 1. In each case this holds whatever the core inputs hold.
- R11: `core_rst_o` is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 3 | Asynchronous control code {read mode, select high, select low} |
| fsk_data_i | input | 1 | Serial data from the FSK path |
| ready_n_i | input | 1 | Active-low byte-ready flag from the FSK read buffer |
| carrier_n_i | input | 1 | Active-low carrier-present flag from the FSK path |
| steer_n_i | input | 1 | Active-low qualified alert flag from the tone path |
| early_i | input | 1 | Raw alert detection from the tone path |
| guard_i | input | 1 | Guard-time drive from the tone path |
| fsk_en_o | output | 1 | FSK demodulator enable |
| rd_mode_o | output | 1 | FSK serial read mode (1 = buffered byte) |
| hyb_alert_en_o | output | 1 | Alert detection on hybrid path |
| tr_alert_en_o | output | 1 | Alert detection on tip/ring path |
| pwrdn_o | output | 1 | Power-down in effect |
| core_rst_o | output | 1 | One-clock core reset after a short power-down visit |
| data_o | output | 1 | Data pin level |
| strobe_n_o | output | 1 | Shared active-low strobe pin level |
| carrier_n_o | output | 1 | Carrier pin level |
| early_o | output | 1 | Raw alert pin level |
| guard_o | output | 1 | Guard-time pin level |

## Verification
Two functions can act on the same clock edge. The power-down filter ends a visit, and the enable register reloads a function code. A short visit to the power-down code is driven, then the code returns to FSK. The bench checks that `core_rst_o` appears on the same edge that reloads the enables, and that the enables held their old values throughout. A second case holds the code for exactly `PD_HOLD`+1 and then `PD_HOLD`+2 clocks, and checks when `pwrdn_o` rises and when the pins are forced to idle levels. A third case leaves a power-down that has taken effect, and checks that `pwrdn_o` falls without a reset pulse on that edge.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic fsk;
    logic mode;
    logic hyb;
    logic tr;
    logic test;
  } fn_sel_t;

  function automatic logic code_is_pd(input logic [CODE_W-1:0] c);
    return c == 3'b100;
  endfunction

  function automatic fn_sel_t decode_code(input logic [CODE_W-1:0] c);
    fn_sel_t s;
    s      = '0;
    s.fsk  = c[1] & c[0];
    s.mode = c[2] & c[1] & c[0];
    s.hyb  = c[1] & ~c[0];
    s.tr   = ~c[1] & c[0];
    s.test = (c == 3'b000);
    return s;
  endfunction
endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mcd_pd_filter.sv
module mcd_pd_filter #(
  parameter int PD_HOLD = 3580
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_code_i,
  output logic pd_o,
  output logic pd_set_o,
  output logic rst_pulse_o
);
  localparam int CW = (PD_HOLD > 2) ? $clog2(PD_HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PD_HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pd_q, pd_d;
  logic          was_q, was_d;
  logic          rst_q, rst_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    pd_d  = pd_q;
    was_d = pd_code_i;
    rst_d = 1'b0;
    if (pd_code_i) begin
      if (at_last) pd_d  = 1'b1;
      else         cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
      pd_d  = 1'b0;
      rst_d = was_q & ~pd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pd_q  <= 1'b0;
      was_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pd_q  <= pd_d;
      was_q <= was_d;
      rst_q <= rst_d;
    end
  end

  assign pd_o        = pd_q;
  assign pd_set_o    = pd_code_i & ~pd_q & at_last;
  assign rst_pulse_o = rst_q;
endmodule

// File: rtl/mcd_sel_reg.sv
module mcd_sel_reg
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pd_code_i,
  input  logic              pd_set_i,
  output fn_sel_t           sel_o
);
  fn_sel_t sel_q, sel_d;
  logic    load_en;

  assign load_en = ~pd_code_i | pd_set_i;

  always_comb begin
    if (!pd_code_i) sel_d = decode_code(code_i);
    else            sel_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      sel_q.test <= 1'b1;
    end else if (load_en) begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/mcd_pin_mux.sv
module mcd_pin_mux
  import mcd_pkg::*;
(
  input  fn_sel_t sel_i,
  input  logic    fsk_data_i,
  input  logic    ready_n_i,
  input  logic    carrier_n_i,
  input  logic    steer_n_i,
  input  logic    early_i,
  input  logic    guard_i,
  output logic    data_o,
  output logic    strobe_n_o,
  output logic    carrier_n_o,
  output logic    early_o,
  output logic    guard_o
);
  logic alert_en;

  assign alert_en = sel_i.hyb | sel_i.tr;

  always_comb begin
    data_o      = 1'b1;
    strobe_n_o  = 1'b1;
    carrier_n_o = 1'b1;
    early_o     = 1'b0;
    guard_o     = 1'b0;
    if (sel_i.fsk) begin
      data_o      = fsk_data_i;
      carrier_n_o = carrier_n_i;
      if (sel_i.mode) strobe_n_o = ready_n_i;
    end else if (alert_en) begin
      strobe_n_o = steer_n_i;
      early_o    = early_i;
      guard_o    = guard_i;
    end
  end
endmodule

// File: rtl/call_mode_ctrl.sv
module call_mode_ctrl
  import mcd_pkg::*;
#(
  parameter int PD_HOLD     = 3580,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_i,
  input  logic       fsk_data_i,
  input  logic       ready_n_i,
  input  logic       carrier_n_i,
  input  logic       steer_n_i,
  input  logic       early_i,
  input  logic       guard_i,
  output logic       fsk_en_o,
  output logic       rd_mode_o,
  output logic       hyb_alert_en_o,
  output logic       tr_alert_en_o,
  output logic       pwrdn_o,
  output logic       core_rst_o,
  output logic       data_o,
  output logic       strobe_n_o,
  output logic       carrier_n_o,
  output logic       early_o,
  output logic       guard_o
);
  logic [CODE_W-1:0] code_s;
  logic              pd_code;
  logic              pd_set;
  fn_sel_t           sel;

  mcd_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cfg_i),
    .q_o   (code_s)
  );

  assign pd_code = code_is_pd(code_s);

  mcd_pd_filter #(.PD_HOLD(PD_HOLD)) i_pd_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_code_i   (pd_code),
    .pd_o        (pwrdn_o),
    .pd_set_o    (pd_set),
    .rst_pulse_o (core_rst_o)
  );

  mcd_sel_reg i_sel_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_i    (code_s),
    .pd_code_i (pd_code),
    .pd_set_i  (pd_set),
    .sel_o     (sel)
  );

  mcd_pin_mux i_pin_mux (
    .sel_i       (sel),
    .fsk_data_i  (fsk_data_i),
    .ready_n_i   (ready_n_i),
    .carrier_n_i (carrier_n_i),
    .steer_n_i   (steer_n_i),
    .early_i     (early_i),
    .guard_i     (guard_i),
    .data_o      (data_o),
    .strobe_n_o  (strobe_n_o),
    .carrier_n_o (carrier_n_o),
    .early_o     (early_o),
    .guard_o     (guard_o)
  );

  assign fsk_en_o       = sel.fsk;
  assign rd_mode_o      = sel.mode;
  assign hyb_alert_en_o = sel.hyb;
  assign tr_alert_en_o  = sel.tr;
endmodule

// File: rtl/call_mode_ctrl_chk.sv
module call_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic fsk_en_o,
  input logic hyb_alert_en_o,
  input logic tr_alert_en_o,
  input logic pwrdn_o,
  input logic core_rst_o,
  input logic data_o,
  input logic strobe_n_o,
  input logic carrier_n_o,
  input logic early_o,
  input logic guard_o
);
  a_r3_one_function: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fsk_en_o, hyb_alert_en_o, tr_alert_en_o}));

  a_r4_pd_no_function: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> (!fsk_en_o && !hyb_alert_en_o && !tr_alert_en_o));

  a_r7_pd_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> (data_o && strobe_n_o && carrier_n_o && !early_o && !guard_o));

  a_r6_no_rst_on_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrdn_o) |-> !core_rst_o);

  a_r6_no_rst_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> !core_rst_o);

  a_r10_fsk_mutes_alert: assert property (@(posedge clk) disable iff (!rst_n)
    fsk_en_o |-> (!early_o && !guard_o));

  a_r11_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |=> !core_rst_o);
endmodule

bind call_mode_ctrl call_mode_ctrl_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fsk_en_o       (fsk_en_o),
  .hyb_alert_en_o (hyb_alert_en_o),
  .tr_alert_en_o  (tr_alert_en_o),
  .pwrdn_o        (pwrdn_o),
  .core_rst_o     (core_rst_o),
  .data_o         (data_o),
  .strobe_n_o     (strobe_n_o),
  .carrier_n_o    (carrier_n_o),
  .early_o        (early_o),
  .guard_o        (guard_o)
);

// File: tb/test_call_mode_ctrl.sv
module test_call_mode_ctrl;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_i = 3'b000;
  logic       fsk_data_i = 1'b0, ready_n_i = 1'b0, carrier_n_i = 1'b0;
  logic       steer_n_i = 1'b0, early_i = 1'b1, guard_i = 1'b1;
  logic       fsk_en_o, rd_mode_o, hyb_alert_en_o, tr_alert_en_o, pwrdn_o, core_rst_o;
  logic       data_o, strobe_n_o, carrier_n_o, early_o, guard_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [10:0] exp;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  call_mode_ctrl #(.PD_HOLD(HOLD)) i_call_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
    .fsk_data_i(fsk_data_i), .ready_n_i(ready_n_i), .carrier_n_i(carrier_n_i),
    .steer_n_i(steer_n_i), .early_i(early_i), .guard_i(guard_i),
    .fsk_en_o(fsk_en_o), .rd_mode_o(rd_mode_o), .hyb_alert_en_o(hyb_alert_en_o),
    .tr_alert_en_o(tr_alert_en_o), .pwrdn_o(pwrdn_o), .core_rst_o(core_rst_o),
    .data_o(data_o), .strobe_n_o(strobe_n_o), .carrier_n_o(carrier_n_o),
    .early_o(early_o), .guard_o(guard_o)
  );

  // Expected pin levels from the requirement rules R7, R9, R10
  function automatic logic [10:0] expect_vec(input logic f, input logic m, input logic h,
                                             input logic t, input logic pd, input logic rs);
    logic d, s, c, e, g;
    d = 1'b1; s = 1'b1; c = 1'b1; e = 1'b0; g = 1'b0;
    if (f) begin
      d = fsk_data_i; c = carrier_n_i;
      if (m) s = ready_n_i;
    end else if (h || t) begin
      s = steer_n_i; e = early_i; g = guard_i;
    end
    return {f, m, h, t, pd, rs, d, s, c, e, g};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input string req, input logic f, input logic m, input logic h,
                      input logic t, input logic pd, input logic rs);
    item_t it;
    it.req = req;
    it.exp = expect_vec(f, m, h, t, pd, rs);
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [10:0] act;
      it  = sb_q.pop_front();
      act = {fsk_en_o, rd_mode_o, hyb_alert_en_o, tr_alert_en_o, pwrdn_o, core_rst_o,
             data_o, strobe_n_o, carrier_n_o, early_o, guard_o};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%b expected=%b", it.req, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R8 reset state: test code, idle pins
    push("R8 reset", 0, 0, 0, 0, 0, 0);
    step(1);

    // R1 FSK mode 0, shared pin reads 1 (R9)
    cfg_i = 3'b011; fsk_data_i = 1'b0; carrier_n_i = 1'b0; ready_n_i = 1'b0;
    step(2);
    push("R1 latency not before third clock", 0, 0, 0, 0, 0, 0);
    step(1);
    push("R1 fsk mode0 / R9 / R10", 1, 0, 0, 0, 0, 0);
    step(1);

    // R1 FSK mode 1, strobe follows ready (R9)
    cfg_i = 3'b111;
    step(3);
    push("R1 fsk mode1 / R9", 1, 1, 0, 0, 0, 0);
    step(1);
    ready_n_i = 1'b1; fsk_data_i = 1'b1; carrier_n_i = 1'b1;
    push("R9 strobe follows ready", 1, 1, 0, 0, 0, 0);
    step(1);

    // R2 hybrid, bit 2 ignored
    cfg_i = 3'b110; steer_n_i = 1'b0; early_i = 1'b1; guard_i = 1'b0; fsk_data_i = 1'b0;
    step(3);
    push("R2 hybrid mode-bit1 / R10", 0, 0, 1, 0, 0, 0);
    step(1);
    cfg_i = 3'b010;
    step(3);
    push("R2 hybrid mode-bit0", 0, 0, 1, 0, 0, 0);
    step(1);
    // R2 tip/ring
    cfg_i = 3'b101; steer_n_i = 1'b1; guard_i = 1'b1;
    step(3);
    push("R2 tip-ring / R9", 0, 0, 0, 1, 0, 0);
    step(1);
    cfg_i = 3'b001; carrier_n_i = 1'b0;
    step(3);
    push("R2 tip-ring mode-bit0 / R10", 0, 0, 0, 1, 0, 0);
    step(1);

    // R8 test code with active core inputs
    cfg_i = 3'b000; early_i = 1'b1; guard_i = 1'b1; steer_n_i = 1'b0;
    step(3);
    push("R8 test code / R7", 0, 0, 0, 0, 0, 0);
    step(1);

    // R5 short visit from FSK mode 0
    cfg_i = 3'b011;
    step(4);
    cfg_i = 3'b100;
    step(3);
    push("R5 enables held in visit", 1, 0, 0, 0, 0, 0);
    cfg_i = 3'b011;
    step(2);
    push("R5 no pulse yet", 1, 0, 0, 0, 0, 0);
    step(1);
    push("R5 reset pulse", 1, 0, 0, 0, 0, 1);
    step(1);
    push("R11 pulse single", 1, 0, 0, 0, 0, 0);
    step(1);

    // R4 full power-down from hybrid
    cfg_i = 3'b110;
    step(4);
    cfg_i = 3'b100; steer_n_i = 1'b0; early_i = 1'b1; guard_i = 1'b1;
    step(HOLD + 1);
    push("R4 one clock short", 0, 0, 1, 0, 0, 0);
    step(1);
    push("R4 power-down / R7", 0, 0, 0, 0, 1, 0);
    step(5);
    push("R4 power-down held", 0, 0, 0, 0, 1, 0);
    step(1);

    // R6 leave power-down to tip/ring: no pulse
    cfg_i = 3'b101;
    step(2);
    push("R6 still down", 0, 0, 0, 0, 1, 0);
    step(1);
    push("R6 exit no pulse", 0, 0, 0, 1, 0, 0);
    step(1);
    push("R6 exit still no pulse", 0, 0, 0, 1, 0, 0);
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule